// File: doc/BRIEF.md
# Serial Receive Path with Per-Byte Error Queue

This block is the receive half of an asynchronous serial port. It watches a serial input line and samples it with a 16x oversampling tick produced elsewhere. It assembles frames of 5 to 8 data bits, with an optional parity bit and one or two stop bits. Each finished character goes into a 16-entry queue. The queue holds the data byte together with a 4-bit error word that belongs to that byte alone.

Software reads a character in two steps. A first strobe copies the head entry's error word into an output register and leaves the entry in the queue. A second strobe copies the data byte into its output register and removes the entry. Queue occupancy is reported as a 4-bit count plus a separate full flag. Three sticky interrupt flags are provided: threshold, error and idle timeout. Writing a one to a flag clears it. Turning the receiver off, or pulsing the queue-clear input, empties the queue.

Top module: `uart_rx_errfifo`

## Requirements
- R1: `dbits_sel` selects 5 + `dbits_sel` data bits. Bits are received LSB first and appear right-aligned in `data_q`, with the unused upper bits read as zero.
- R2: `stop_sel` selects 1 + `stop_sel` stop bits. If any stop bit is sampled low, error bit 2 (frame) of that byte's entry is set.
- R3: `par_sel` selects the parity mode: 0 none, 1 odd, 2 even, 3 forced one, 4 forced zero; codes 5 to 7 behave as none. A parity bit that does not match sets error bit 1 of the entry.
- R4: A frame whose every bit (start, data, parity, stop) is low is stored as data 0 with error bits 3 (break) and 2 set. The next frame is only recognised after the line has returned high, so a long low produces one entry.
- R5: The occupancy is reported on `fifo_cnt` and `fifo_full`. From 0 to 15 entries, `fifo_cnt` gives the count and `fifo_full` is 0. With 16 entries, `fifo_full` is 1 and `fifo_cnt` is 0.
- R6: A pulse on `rd_err` loads the head entry's error word into `err_q` on the next clock edge and leaves the entry in place. A pulse on `rd_data` loads the head data into `data_q` and removes the entry.
- R7: A frame that completes while the queue is full, with no removal in the same cycle, is dropped. Error bit 0 (overrun) is then set on the current head entry, which is the next byte to be read.
- R8: Each `irq_stat` bit is sticky. A one on the matching bit of `irq_clr` clears it. An event in the same cycle as a clear wins, and later events set the bit again.
- R9: `irq_stat[0]` is set while the occupancy is at least `trig_lvl` + 1.
- R10: `irq_stat[1]` is set when a stored byte carries a parity, frame or break error, and when an overrun occurs.
- R11: `irq_stat[2]` is set once the line has been idle for 3 character times (48 ticks per frame bit) after the last stored byte. It is set even if the queue has been emptied meanwhile, and only once per stored byte.
- R12: While `rx_en` is low, the queue is empty and any frame in progress is abandoned. A pulse on `fifo_clr` empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | 16x bit-rate sampling strobe |
| rxd | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Receiver enable; low resets queue and framer |
| dbits_sel | input | 2 | Data length code (length minus 5) |
| stop_sel | input | 1 | Stop length code (length minus 1) |
| par_sel | input | 3 | Parity mode code |
| trig_lvl | input | 4 | Threshold code (level minus 1) |
| fifo_clr | input | 1 | Queue clear pulse |
| rd_err | input | 1 | Load head error word into err_q |
| rd_data | input | 1 | Load head data into data_q and remove entry |
| irq_clr | input | 3 | Write-one-to-clear for irq_stat |
| err_q | output | 4 | Error word: bit3 break, bit2 frame, bit1 parity, bit0 overrun |
| data_q | output | 8 | Received data |
| fifo_cnt | output | 4 | Occupancy count (modulo 16) |
| fifo_full | output | 1 | Queue holds 16 entries |
| irq_stat | output | 3 | bit0 threshold, bit1 error, bit2 timeout |

## Verification
A character is stored in the middle of its last stop bit, plus two clocks of input synchronisation. The bench therefore samples the count, the flags and the threshold state only after it has driven the whole stop time and a further bit of idle line. `err_q` and `data_q` change on the edge that follows their strobe, and the bench reads them at the next falling edge. The timeout is checked on both sides of its 48-ticks-per-bit deadline: once well before it, once well after it, and once more after a further full period to confirm it does not fire again.

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo #(
  parameter int AW = 4,
  parameter int TOUT_CHARS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic [1:0]    dbits_sel,
  input  logic          stop_sel,
  input  logic [2:0]    par_sel,
  input  logic [AW-1:0] trig_lvl,
  input  logic          fifo_clr,
  input  logic          rd_err,
  input  logic          rd_data,
  input  logic [2:0]    irq_clr,
  output logic [3:0]    err_q,
  output logic [7:0]    data_q,
  output logic [AW-1:0] fifo_cnt,
  output logic          fifo_full,
  output logic [2:0]    irq_stat
);
  localparam int DEPTH = 1 << AW;
  localparam int TW = $clog2(TOUT_CHARS * 16 * 12 + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} st_t;

  logic [1:0] rx_sync;
  logic       rxs;
  st_t        st;
  logic [3:0] tcnt;
  logic [2:0] bitn;
  logic       stopn;
  logic [7:0] sh;
  logic       allz, pbit, ferr;

  always_ff @(posedge clk)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};
  assign rxs = rx_sync[1];

  wire [3:0] nbits   = 4'd5 + {2'b00, dbits_sel};
  wire       has_par = (par_sel >= 3'd1) && (par_sel <= 3'd4);
  wire       mid     = os_tick && (tcnt == 4'd15);
  wire       push    = (st == S_STOP) && mid && (stopn == stop_sel);

  wire [7:0] rdata    = sh >> (4'd8 - nbits);
  wire       xr       = ^rdata;
  wire       exp_par  = (par_sel == 3'd1) ? ~xr : (par_sel == 3'd2) ? xr : (par_sel == 3'd3);
  wire       perr     = has_par && (pbit != exp_par);
  wire       ferr_fin = ferr | ~rxs;
  wire       brk      = allz & ~rxs;
  wire [3:0] err_new  = {brk, ferr_fin, perr, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      st <= S_IDLE; tcnt <= '0; bitn <= '0; stopn <= 1'b0;
      sh <= '0; allz <= 1'b0; pbit <= 1'b0; ferr <= 1'b0;
    end else if (os_tick) begin
      case (st)
        S_IDLE: begin
          tcnt <= '0;
          if (!rxs) st <= S_START;
        end
        S_START: begin
          if (tcnt == 4'd7) begin
            st <= rxs ? S_IDLE : S_DATA;
            tcnt <= '0; bitn <= '0; stopn <= 1'b0;
            allz <= 1'b1; ferr <= 1'b0;
          end else tcnt <= tcnt + 4'd1;
        end
        S_DATA: begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            sh <= {rxs, sh[7:1]};
            allz <= allz & ~rxs;
            bitn <= bitn + 3'd1;
            if ({1'b0, bitn} == nbits - 4'd1) st <= has_par ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            pbit <= rxs; allz <= allz & ~rxs; st <= S_STOP;
          end
        end
        S_STOP: begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            ferr <= ferr_fin; allz <= brk;
            if (stopn == stop_sel) st <= rxs ? S_IDLE : S_WAITHI;
            else stopn <= 1'b1;
          end
        end
        default: if (rxs) st <= S_IDLE;
      endcase
    end
  end

  logic          armed;
  logic [TW-1:0] tocnt;
  wire  [3:0]    fbits    = 4'd2 + nbits + {3'b000, has_par} + {3'b000, stop_sel};
  wire  [TW-1:0] tout_lim = TW'(TOUT_CHARS * 16) * TW'(fbits);
  wire           tout_hit = armed && os_tick && (st == S_IDLE) && (tocnt == tout_lim - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      armed <= 1'b0; tocnt <= '0;
    end else if (push) begin
      armed <= 1'b1; tocnt <= '0;
    end else if (st != S_IDLE) tocnt <= '0;
    else if (armed && os_tick) begin
      if (tout_hit) begin armed <= 1'b0; tocnt <= '0; end
      else tocnt <= tocnt + TW'(1);
    end
  end

  logic [11:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   occ;

  wire pop  = rd_data && (occ != '0);
  wire full = (occ == (AW+1)'(DEPTH));
  wire wr   = push && (!full || pop);
  wire ovr  = push && full && !pop;

  always_ff @(posedge clk) begin
    if (wr)  mem[wp] <= {err_new, rdata};
    if (ovr) mem[rp][8] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en || fifo_clr) begin
      wp <= '0; rp <= '0; occ <= '0;
    end else begin
      if (wr)  wp <= wp + AW'(1);
      if (pop) rp <= rp + AW'(1);
      occ <= occ + (AW+1)'(wr) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0; data_q <= '0;
    end else begin
      if (rd_err && occ != '0) err_q <= mem[rp][11:8];
      if (pop) data_q <= mem[rp][7:0];
    end
  end

  assign fifo_cnt  = occ[AW-1:0];
  assign fifo_full = occ[AW];

  wire [2:0] irq_set = {tout_hit,
                        (wr && (err_new[3:1] != 3'b000)) || ovr,
                        occ >= ({1'b0, trig_lvl} + (AW+1)'(1))};

  always_ff @(posedge clk)
    if (!rst_n) irq_stat <= '0;
    else        irq_stat <= (irq_stat & ~irq_clr) | irq_set;

endmodule

// File: rtl/uart_rx_errfifo_chk.sv
module uart_rx_errfifo_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          fifo_clr,
  input logic          rd_data,
  input logic          push,
  input logic [AW:0]   occ,
  input logic [AW-1:0] fifo_cnt,
  input logic          fifo_full,
  input logic [2:0]    irq_clr,
  input logic [2:0]    irq_set,
  input logic [2:0]    irq_stat
);
  localparam int DEPTH = 1 << AW;

  AST_FULL_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (fifo_cnt == '0)); // R5
  AST_OCC_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(DEPTH)); // R5
  AST_POP_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !fifo_clr && rd_data && occ != '0 && !push) |=> (occ == $past(occ) - (AW+1)'(1))); // R6
  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (occ == '0)); // R12
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_clr & irq_stat & ~irq_set) != 3'b000) |=> ((irq_stat & $past(irq_clr & irq_stat & ~irq_set)) == 3'b000)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != 3'b000) |=> ((irq_stat & $past(irq_set)) == $past(irq_set))); // R8
endmodule

bind uart_rx_errfifo uart_rx_errfifo_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fifo_clr(fifo_clr),
  .rd_data(rd_data), .push(push), .occ(occ), .fifo_cnt(fifo_cnt),
  .fifo_full(fifo_full), .irq_clr(irq_clr), .irq_set(irq_set),
  .irq_stat(irq_stat)
);

// File: tb/uart_rx_errfifo_tb_top.sv
module uart_rx_errfifo_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic rx_en = 1'b0;
  logic [1:0] dbits_sel = 2'd3;
  logic stop_sel = 1'b0;
  logic [2:0] par_sel = 3'd0;
  logic [3:0] trig_lvl = 4'd15;
  logic fifo_clr = 1'b0, rd_err = 1'b0, rd_data = 1'b0;
  logic [2:0] irq_clr = 3'b000;
  logic [3:0] err_q;
  logic [7:0] data_q;
  logic [3:0] fifo_cnt;
  logic fifo_full;
  logic [2:0] irq_stat;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_errfifo dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
    .dbits_sel(dbits_sel), .stop_sel(stop_sel), .par_sel(par_sel),
    .trig_lvl(trig_lvl), .fifo_clr(fifo_clr), .rd_err(rd_err),
    .rd_data(rd_data), .irq_clr(irq_clr), .err_q(err_q), .data_q(data_q),
    .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .irq_stat(irq_stat)
  );

  initial forever begin
    @(negedge clk);
    os_tick = ~os_tick;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input bit v, input int bits);
    rxd = v;
    repeat (bits * 32) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input int pm, input int sb,
                      input bit bad_par, input bit bad_stop);
    logic [7:0] dm;
    logic p;
    dm = d & ((8'd1 << nb) - 8'd1);
    p = (pm == 1) ? ~^dm : (pm == 2) ? ^dm : (pm == 3) ? 1'b1 : 1'b0;
    hold(1'b0, 1);
    for (int i = 0; i < nb; i++) hold(dm[i], 1);
    if (pm >= 1 && pm <= 4) hold(p ^ bad_par, 1);
    hold(~bad_stop, 1);
    if (sb == 2) hold(1'b1, 1);
    hold(1'b1, 1);
  endtask

  task automatic rd_one;
    @(negedge clk); rd_err = 1'b1;
    @(negedge clk); rd_err = 1'b0; rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic pulse_clr(input logic [2:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = 3'b000;
  endtask

  task automatic flush;
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_cnt == 0 && fifo_full == 0, "R5 reset occupancy", {fifo_full, fifo_cnt}, 0);
    chk(irq_stat == 0, "R8 reset flags", irq_stat, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    for (int nb = 5; nb <= 8; nb++)
      for (int pm = 0; pm <= 4; pm++)
        for (int sb = 1; sb <= 2; sb++)
          for (int bp = 0; bp <= ((pm == 0) ? 0 : 1); bp++) begin
            logic [7:0] d, dm;
            d = 8'hA5 ^ 8'(nb * 37 + pm * 11 + sb * 5 + bp * 3);
            dm = d & ((8'd1 << nb) - 8'd1);
            dbits_sel = 2'(nb - 5); par_sel = 3'(pm); stop_sel = 1'(sb - 1);
            send(d, nb, pm, sb, bit'(bp), 1'b0);
            chk(fifo_cnt == 1, "R1 one entry stored", fifo_cnt, 1);
            rd_one();
            chk(data_q == dm, "R1 data length and alignment", data_q, dm);
            chk(err_q == (bp ? 4'b0010 : 4'b0000), "R3 parity result", err_q, bp ? 2 : 0);
          end

    dbits_sel = 2'd3; par_sel = 3'd0; stop_sel = 1'b0;
    flush(); pulse_clr(3'b111);
    send(8'h5A, 8, 0, 1, 1'b0, 1'b1);
    rd_one();
    chk(err_q == 4'b0100 && data_q == 8'h5A, "R2 frame error", {err_q, data_q}, 12'h45A);
    chk(irq_stat[1] == 1'b1, "R10 error flag on frame error", irq_stat, 2);

    stop_sel = 1'b1;
    send(8'h3C, 8, 0, 2, 1'b0, 1'b0);
    rd_one();
    chk(err_q == 4'b0000 && data_q == 8'h3C, "R2 two stop bits good", {err_q, data_q}, 12'h03C);
    stop_sel = 1'b0;

    hold(1'b0, 13); hold(1'b1, 2);
    chk(fifo_cnt == 1, "R4 single break entry", fifo_cnt, 1);
    rd_one();
    chk(err_q == 4'b1100 && data_q == 8'h00, "R4 break word", {err_q, data_q}, 12'hC00);

    flush(); pulse_clr(3'b111);
    for (int i = 0; i < 16; i++) send(8'(8'h10 + i), 8, 0, 1, 1'b0, 1'b0);
    chk(fifo_full == 1 && fifo_cnt == 0, "R5 full encoding", {fifo_full, fifo_cnt}, 16);
    chk(irq_stat[1] == 1'b0, "R10 no error flag before overrun", irq_stat, 0);
    send(8'hEE, 8, 0, 1, 1'b0, 1'b0);
    chk(fifo_full == 1 && fifo_cnt == 0, "R7 dropped byte", {fifo_full, fifo_cnt}, 16);
    chk(irq_stat[1] == 1'b1, "R10 error flag on overrun", irq_stat, 2);
    @(negedge clk); rd_err = 1'b1;
    @(negedge clk); rd_err = 1'b0;
    @(negedge clk);
    chk(fifo_full == 1 && err_q == 4'b0001, "R6 error read keeps entry", {fifo_full, err_q}, 5'h11);
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
    chk(data_q == 8'h10 && fifo_cnt == 15, "R7 head data after overrun", {data_q, fifo_cnt}, 12'h10F);
    rd_one();
    chk(err_q == 4'b0000 && data_q == 8'h11, "R7 overrun only on first", {err_q, data_q}, 12'h011);
    chk(fifo_cnt == 14, "R5 count after reads", fifo_cnt, 14);

    flush(); trig_lvl = 4'd2; pulse_clr(3'b111);
    send(8'h01, 8, 0, 1, 1'b0, 1'b0);
    send(8'h02, 8, 0, 1, 1'b0, 1'b0);
    chk(irq_stat[0] == 1'b0, "R9 below threshold", irq_stat, 0);
    send(8'h03, 8, 0, 1, 1'b0, 1'b0);
    chk(irq_stat[0] == 1'b1, "R9 threshold reached", irq_stat, 1);
    rd_one(); pulse_clr(3'b001);
    @(negedge clk);
    chk(irq_stat[0] == 1'b0, "R8 clear after level dropped", irq_stat, 0);
    trig_lvl = 4'd15;

    flush();
    send(8'h77, 8, 0, 1, 1'b0, 1'b0);
    rd_one(); pulse_clr(3'b111);
    repeat (700) @(negedge clk);
    chk(irq_stat[2] == 1'b0, "R11 no early timeout", irq_stat, 0);
    repeat (400) @(negedge clk);
    chk(irq_stat[2] == 1'b1 && fifo_cnt == 0, "R11 timeout with empty queue", {irq_stat, fifo_cnt}, 64);
    pulse_clr(3'b100);
    @(negedge clk);
    chk(irq_stat[2] == 1'b0, "R8 write one clears timeout", irq_stat, 0);
    repeat (1200) @(negedge clk);
    chk(irq_stat[2] == 1'b0, "R11 timeout once per byte", irq_stat, 0);

    send(8'h21, 8, 0, 1, 1'b0, 1'b0);
    send(8'h22, 8, 0, 1, 1'b0, 1'b0);
    chk(fifo_cnt == 2, "R12 two stored", fifo_cnt, 2);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    chk(fifo_cnt == 0 && fifo_full == 0, "R12 disable empties", fifo_cnt, 0);
    send(8'h23, 8, 0, 1, 1'b0, 1'b0);
    flush();
    @(negedge clk);
    chk(fifo_cnt == 0, "R12 clear pulse empties", fifo_cnt, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule